// File: doc/BRIEF.md
# Descriptor Ring Stream Reader

This block is a read-direction DMA engine that walks a circular list of buffer descriptors held in memory. For each descriptor it fetches four words (buffer address low, buffer address high, byte length, flags). It then reads the described buffer one 32-bit word at a time and sends the bytes out on a valid/ready stream. The descriptor list wraps back to entry 0 after a programmable last index. A running byte position tracks progress through the cyclic data buffer and wraps at a programmable cyclic length.

Software can bound the engine with a position limit. When the limit is enabled, the engine never reads a byte at or beyond the limit offset; it waits there until software moves the limit forward, so the buffer can be refilled while the engine runs. Run and stream reset are both handshakes: the control register reads back the engine's real state rather than the last written value. Completion is flagged per descriptor, and faults (zero-length descriptor or memory read error) stop the engine and flag an error. Either event can raise a level interrupt that is gated by a per-stream enable and a global enable.

Top module: `ring_dma_reader`

## Requirements
- R1: After synchronous reset the control, status and position registers read 0, `irq` is low, `out_valid` is low and no memory request is issued.
- R2: Descriptor i is fetched from ring base + 16*i as four words: address low, address high, byte length, flags. Only flags bit 0 (completion request) has an effect; the other flag bits are ignored.
- R3: Register 2 (ring base low) ignores write bits 6:0 and reads them back as zero.
- R4: After finishing the descriptor whose index equals register 5 (last index), the engine continues with descriptor 0.
- R5: Register 8 reads the byte position. It advances by the bytes delivered and wraps to 0 on reaching register 4 (cyclic length).
- R6: With register 7 bit 0 set, a data word is read only when all of its bytes lie below the register 6 limit, counted forward from the position modulo the cyclic length. Otherwise the engine stalls until the limit moves.
- R7: Stream words carry buffer bytes little-endian, with byte lane k valid when `out_keep[k]` is set. Only the final word of a descriptor may be partial, and its unused lanes are zero. `out_last` marks that word, and `out_tag` equals control bits 23:20.
- R8: Under backpressure a presented word stays stable until accepted, and no word is lost or duplicated.
- R9: Writing control bit 0 = 1 enters stream reset. Bit 0 reads back 1 once in reset, and position and descriptor state read back as zero. Writing bit 0 = 0 leaves reset, and bit 0 then reads back 0.
- R10: Writing control bit 1 = 1 starts the engine, and bit 1 reads back 1 while running. After bit 1 is cleared, the engine stops at the next point with no memory read in flight, and bit 1 then reads back 0.
- R11: Completing a descriptor whose flags bit 0 is set sets status bit 0; completing one without it leaves status bit 0 unchanged. Status bits are write-1-to-clear. `irq` is high exactly when `glob_irq_en`, control bit 2 and (status bit 0 or status bit 1) are all set.
- R12: A descriptor with byte length 0, or a read response with `mem_rsp_err` set, sets status bit 1 and clears the run request, and the engine stops.
- R13: A memory request holds its address until accepted, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| glob_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Level interrupt |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 64 | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream word accepted |
| out_data | output | 32 | Stream data, little-endian bytes |
| out_keep | output | 4 | Byte lane valid mask |
| out_last | output | 1 | Final word of a descriptor |
| out_tag | output | 4 | Stream tag from control |

## Verification
The assertions assume that memory responses arrive only while a read is outstanding. They also assume that the cyclic length and the limit-enable bit are changed only while the engine is idle or in stream reset, and that the limit is only moved forward while the engine runs. They further assume that data buffers start on 4-byte boundaries and that software matches the cyclic length to the sum of the descriptor lengths. The bench memory model answers one request at a time with random acceptance and latency, and the bench programs every ring before starting the engine. Each ring is followed by a stream reset and reprogramming, and the limit is only raised during the staged position-limit test.

// File: rtl/ring_dma_pkg.sv
// Shared constants, register indexes and helpers for the descriptor ring reader.
package ring_dma_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 64;
    localparam int BYTES    = DATA_W / 8;
    localparam int CSR_AW   = 4;

    localparam logic [CSR_AW-1:0] RA_CTRL    = 4'd0;
    localparam logic [CSR_AW-1:0] RA_STAT    = 4'd1;
    localparam logic [CSR_AW-1:0] RA_RING_LO = 4'd2;
    localparam logic [CSR_AW-1:0] RA_RING_HI = 4'd3;
    localparam logic [CSR_AW-1:0] RA_CYC     = 4'd4;
    localparam logic [CSR_AW-1:0] RA_LAST    = 4'd5;
    localparam logic [CSR_AW-1:0] RA_LIMIT   = 4'd6;
    localparam logic [CSR_AW-1:0] RA_LIMEN   = 4'd7;
    localparam logic [CSR_AW-1:0] RA_POS     = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_FREQ, ST_FWAIT, ST_DREQ, ST_DWAIT, ST_RST
    } eng_state_t;

    // Byte-lane mask for a word carrying n bytes (1..4).
    function automatic logic [BYTES-1:0] keep_of(input logic [2:0] n);
        logic [BYTES-1:0] m;
        for (int b = 0; b < BYTES; b++) m[b] = (3'(b) < n);
        return m;
    endfunction
endpackage

// File: rtl/ring_dma_csr.sv
// Register file of the ring reader.
// Holds configuration, run/reset requests, sticky status and the interrupt gate.
// Assumes: single-cycle writes, combinational reads selected by csr_addr.
module ring_dma_csr
    import ring_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    input  logic               glob_irq_en,
    output logic               irq,
    output logic               run_req,
    output logic               srst_req,
    output logic [ADDR_W-1:0]  ring_base,
    output logic [31:0]        cyc_len,
    output logic [IDX_W-1:0]   last_idx,
    output logic [31:0]        lim_val,
    output logic               lim_en,
    output logic [3:0]         tag,
    input  logic               running,
    input  logic               srst_ack,
    input  logic [31:0]        pos,
    input  logic               done_set,
    input  logic               err_set,
    input  logic               run_clr
);
    logic        ie;
    logic        st_done;
    logic        st_err;
    logic [24:0] ring_lo_q;
    logic [31:0] ring_hi_q;

    assign ring_base = {ring_hi_q, ring_lo_q, 7'b0};

    // Register writes, engine event capture and run clear (engine events win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_req   <= 1'b0;
            srst_req  <= 1'b0;
            ie        <= 1'b0;
            tag       <= 4'd0;
            st_done   <= 1'b0;
            st_err    <= 1'b0;
            ring_lo_q <= '0;
            ring_hi_q <= '0;
            cyc_len   <= '0;
            last_idx  <= '0;
            lim_val   <= '0;
            lim_en    <= 1'b0;
        end else begin
            if (csr_we) begin
                case (csr_addr)
                    RA_CTRL: begin
                        srst_req <= csr_wdata[0];
                        run_req  <= csr_wdata[1];
                        ie       <= csr_wdata[2];
                        tag      <= csr_wdata[23:20];
                    end
                    RA_STAT: begin
                        if (csr_wdata[0]) st_done <= 1'b0;
                        if (csr_wdata[1]) st_err  <= 1'b0;
                    end
                    RA_RING_LO: ring_lo_q <= csr_wdata[31:7];
                    RA_RING_HI: ring_hi_q <= csr_wdata;
                    RA_CYC:     cyc_len   <= csr_wdata;
                    RA_LAST:    last_idx  <= csr_wdata[IDX_W-1:0];
                    RA_LIMIT:   lim_val   <= csr_wdata;
                    RA_LIMEN:   lim_en    <= csr_wdata[0];
                    default: ;
                endcase
            end
            if (done_set) st_done <= 1'b1;
            if (err_set)  st_err  <= 1'b1;
            if (run_clr)  run_req <= 1'b0;
        end
    end

    // Read mux: control reports live engine state, not the written request bits.
    always_comb begin
        case (csr_addr)
            RA_CTRL:    csr_rdata = {8'd0, tag, 17'd0, ie, running, srst_ack};
            RA_STAT:    csr_rdata = {30'd0, st_err, st_done};
            RA_RING_LO: csr_rdata = {ring_lo_q, 7'b0};
            RA_RING_HI: csr_rdata = ring_hi_q;
            RA_CYC:     csr_rdata = cyc_len;
            RA_LAST:    csr_rdata = 32'(last_idx);
            RA_LIMIT:   csr_rdata = lim_val;
            RA_LIMEN:   csr_rdata = {31'd0, lim_en};
            RA_POS:     csr_rdata = pos;
            default:    csr_rdata = 32'd0;
        endcase
    end

    // Interrupt gate: both enables and any sticky status.
    assign irq = glob_irq_en & ie & (st_done | st_err);

    // Status completion bit only rises on an engine completion event.
    assert_done_from_engine_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> $past(done_set));
    // Error bit only rises on an engine fault, and the fault drops the run request.
    assert_err_from_engine_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_err) |-> ($past(err_set) && !run_req));
endmodule

// File: rtl/ring_dma_outstage.sv
// Single-entry output holding stage for the stream port.
// Assumes: the engine loads only when the stage is empty (one read outstanding).
module ring_dma_outstage
    import ring_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [BYTES-1:0]  ld_keep,
    input  logic              ld_last,
    output logic              empty,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [BYTES-1:0]  out_keep,
    output logic              out_last
);
    // Hold a word until the sink takes it; flush drops it during stream reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_keep  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_keep  <= ld_keep;
            out_last  <= ld_last;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign empty = !out_valid;

    // A new word never lands on one not yet taken.
    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
    // A presented word stays put until accepted.
    assert_hold_under_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)));
endmodule

// File: rtl/ring_dma_engine.sv
// Descriptor walker and data reader.
// Fetches four-word descriptors, reads buffer words subject to the position
// limit, advances the cyclic byte position and reports completion and faults.
// Assumes: buffer addresses are 4-byte aligned; one memory read outstanding.
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              srst_req,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [31:0]       cyc_len,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [31:0]       lim_val,
    input  logic              lim_en,
    output logic              running,
    output logic              srst_ack,
    output logic [31:0]       pos,
    output logic              done_set,
    output logic              err_set,
    output logic              run_clr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    input  logic              ob_empty,
    output logic              ob_load,
    output logic [DATA_W-1:0] ob_data,
    output logic [BYTES-1:0]  ob_keep,
    output logic              ob_last,
    output logic              ob_flush
);
    eng_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        wsel;
    logic [ADDR_W-1:0] buf_addr;
    logic [31:0]       dlen;
    logic              dflag;
    logic [31:0]       dofs;
    logic              loaded;

    logic [31:0]       rem;
    logic [2:0]        nbytes;
    logic [31:0]       avail;
    logic              lim_ok;
    logic [32:0]       psum;
    logic [31:0]       pos_nxt;
    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] data_addr;
    logic              fetch_fault;
    logic              data_fault;

    // Bytes left in the current descriptor and the size of the next word.
    always_comb begin
        rem    = dlen - dofs;
        nbytes = (rem >= 32'd4) ? 3'd4 : rem[2:0];
    end

    // Room before the limit, measured forward around the cyclic buffer.
    always_comb begin
        avail  = (lim_val >= pos) ? (lim_val - pos) : (lim_val + cyc_len - pos);
        lim_ok = !lim_en || (avail >= 32'(nbytes));
    end

    // Next byte position, wrapping at the cyclic length.
    always_comb begin
        psum    = {1'b0, pos} + 33'(nbytes);
        pos_nxt = (psum >= {1'b0, cyc_len}) ? 32'(psum - {1'b0, cyc_len}) : psum[31:0];
    end

    // Request addresses for descriptor words and data words.
    always_comb begin
        desc_addr     = ring_base + ADDR_W'({idx, 4'b0000}) + ADDR_W'({wsel, 2'b00});
        data_addr     = buf_addr + ADDR_W'(dofs);
        mem_req_valid = (state == ST_FREQ) || (state == ST_DREQ);
        mem_req_addr  = (state == ST_FREQ) ? desc_addr : data_addr;
    end

    // Fault detection and event pulses toward the register file.
    always_comb begin
        fetch_fault = (state == ST_FWAIT) && mem_rsp_valid &&
                      (mem_rsp_err || (wsel == 2'd2 && mem_rsp_data == '0));
        data_fault  = (state == ST_DWAIT) && mem_rsp_valid && mem_rsp_err;
        err_set     = fetch_fault || data_fault;
        run_clr     = err_set;
        ob_load     = (state == ST_DWAIT) && mem_rsp_valid && !mem_rsp_err;
        ob_keep     = keep_of(nbytes);
        ob_last     = (rem <= 32'd4);
        done_set    = ob_load && ob_last && dflag;
        ob_flush    = (state == ST_RST);
        running     = (state != ST_IDLE) && (state != ST_RST);
        srst_ack    = (state == ST_RST);
    end

    // Zero the unused byte lanes of a partial word.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign ob_data[8*b +: 8] = ob_keep[b] ? mem_rsp_data[8*b +: 8] : 8'h00;
    end

    // Main sequencer: descriptor fetch, limited data reads, stop and reset handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            wsel     <= '0;
            buf_addr <= '0;
            dlen     <= '0;
            dflag    <= 1'b0;
            dofs     <= '0;
            loaded   <= 1'b0;
            pos      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (srst_req)     state <= ST_RST;
                    else if (run_req) state <= ST_CHK;
                end
                ST_CHK: begin
                    if (srst_req || !run_req)    state <= ST_IDLE;
                    else if (!loaded)            state <= ST_FREQ;
                    else if (ob_empty && lim_ok) state <= ST_DREQ;
                end
                ST_FREQ: if (mem_req_ready) state <= ST_FWAIT;
                ST_FWAIT: if (mem_rsp_valid) begin
                    if (fetch_fault) begin
                        wsel  <= '0;
                        state <= ST_IDLE;
                    end else begin
                        case (wsel)
                            2'd0: buf_addr[31:0]  <= mem_rsp_data;
                            2'd1: buf_addr[63:32] <= mem_rsp_data;
                            2'd2: dlen            <= mem_rsp_data;
                            default: begin
                                dflag  <= mem_rsp_data[0];
                                dofs   <= '0;
                                loaded <= 1'b1;
                            end
                        endcase
                        wsel  <= wsel + 2'd1;
                        state <= ST_CHK;
                    end
                end
                ST_DREQ: if (mem_req_ready) state <= ST_DWAIT;
                ST_DWAIT: if (mem_rsp_valid) begin
                    if (data_fault) begin
                        loaded <= 1'b0;
                        wsel   <= '0;
                        state  <= ST_IDLE;
                    end else begin
                        pos <= pos_nxt;
                        if (ob_last) begin
                            loaded <= 1'b0;
                            idx    <= (idx == last_idx) ? '0 : idx + IDX_W'(1);
                        end else begin
                            dofs <= dofs + 32'(nbytes);
                        end
                        state <= ST_CHK;
                    end
                end
                ST_RST: begin
                    idx      <= '0;
                    wsel     <= '0;
                    buf_addr <= '0;
                    dlen     <= '0;
                    dflag    <= 1'b0;
                    dofs     <= '0;
                    loaded   <= 1'b0;
                    pos      <= '0;
                    if (!srst_req) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Requests hold their address until accepted.
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // Responses only arrive for the single outstanding read.
    assert_rsp_expected_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (state == ST_FWAIT || state == ST_DWAIT));
    // Position stays inside the cyclic buffer while running.
    assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cyc_len != 32'd0) |-> (pos < cyc_len));
    // An issued data read never covers bytes at or past the limit.
    assert_limit_respected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DREQ && lim_en) |-> (avail >= 32'(nbytes)));
    // Reset handshake clears the position.
    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_ack && $past(srst_ack)) |-> (pos == 32'd0 && !loaded));
endmodule

// File: rtl/ring_dma_reader.sv
// Top of the descriptor ring stream reader: register file, engine, output stage.
// Assumes: single memory read port with in-order responses.
module ring_dma_reader
    import ring_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              glob_irq_en,
    output logic              irq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [BYTES-1:0]  out_keep,
    output logic              out_last,
    output logic [3:0]        out_tag
);
    logic              run_req, srst_req, lim_en;
    logic [ADDR_W-1:0] ring_base;
    logic [31:0]       cyc_len, lim_val, pos;
    logic [IDX_W-1:0]  last_idx;
    logic              running, srst_ack, done_set, err_set, run_clr;
    logic              ob_empty, ob_load, ob_last, ob_flush;
    logic [DATA_W-1:0] ob_data;
    logic [BYTES-1:0]  ob_keep;

    ring_dma_csr #(.IDX_W(IDX_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .glob_irq_en(glob_irq_en), .irq(irq),
        .run_req(run_req), .srst_req(srst_req), .ring_base(ring_base),
        .cyc_len(cyc_len), .last_idx(last_idx), .lim_val(lim_val), .lim_en(lim_en),
        .tag(out_tag),
        .running(running), .srst_ack(srst_ack), .pos(pos),
        .done_set(done_set), .err_set(err_set), .run_clr(run_clr)
    );

    ring_dma_engine #(.IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .run_req(run_req), .srst_req(srst_req), .ring_base(ring_base),
        .cyc_len(cyc_len), .last_idx(last_idx), .lim_val(lim_val), .lim_en(lim_en),
        .running(running), .srst_ack(srst_ack), .pos(pos),
        .done_set(done_set), .err_set(err_set), .run_clr(run_clr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .ob_empty(ob_empty), .ob_load(ob_load), .ob_data(ob_data), .ob_keep(ob_keep),
        .ob_last(ob_last), .ob_flush(ob_flush)
    );

    ring_dma_outstage u_out (
        .clk(clk), .rst_n(rst_n), .flush(ob_flush),
        .load(ob_load), .ld_data(ob_data), .ld_keep(ob_keep), .ld_last(ob_last),
        .empty(ob_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );
endmodule

// File: tb/ring_dma_reader_tb.sv
`timescale 1ns/1ps
module ring_dma_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = 4'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic        glob_irq_en = 1'b0;
    logic        irq;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'd0;
    logic        mem_rsp_err = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_keep;
    logic        out_last;
    logic [3:0]  out_tag;

    ring_dma_reader u_dut (.*);

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [31:0] mem [0:1023];
    logic [63:0] err_addr = '1;
    int rdy_pct = 100;
    logic [31:0] rx_data [0:2047];
    logic [3:0]  rx_keep [0:2047];
    logic        rx_last [0:2047];
    int rx_cnt = 0;
    int tag_bad = 0;
    logic [3:0] cur_tag = 4'd0;
    int d_addr [0:3];
    int d_len  [0:3];
    bit d_flag [0:3];
    int nd = 0;

    // Memory model: one read at a time, random acceptance and latency.
    bit pend = 0;
    int lat = 0;
    logic [63:0] pa = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_req_ready = 1'b0;
        if (rst_n) begin
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[pa[11:2]];
                    mem_rsp_err   = (pa == err_addr);
                    pend = 0;
                end else lat--;
            end
            if (mem_req_valid && !pend && ($urandom % 4 != 0)) begin
                mem_req_ready = 1'b1;
                pend = 1;
                pa = mem_req_addr;
                lat = $urandom % 3;
            end
        end
    end

    // Stream sink with random backpressure; records accepted words.
    always @(negedge clk) begin
        out_ready = (($urandom % 100) < rdy_pct);
        if (rst_n && out_valid && out_ready) begin
            rx_data[rx_cnt] = out_data;
            rx_keep[rx_cnt] = out_keep;
            rx_last[rx_cnt] = out_last;
            if (out_tag != cur_tag) tag_bad++;
            rx_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic poll(input logic [3:0] a, input logic [31:0] mask, input logic [31:0] want,
                        input string req);
        logic [31:0] v = 0;
        for (int i = 0; i < 60; i++) begin
            rd(a, v);
            if ((v & mask) == want) break;
        end
        check((v & mask) == want, req, v & mask, want);
    endtask

    function automatic logic [3:0] keepf(input int n);
        return (n >= 4) ? 4'hF : 4'((1 << n) - 1);
    endfunction

    function automatic logic [31:0] maskw(input logic [31:0] w, input logic [3:0] k);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = k[b] ? w[8*b +: 8] : 8'h00;
        return r;
    endfunction

    // Place descriptor i into the ring at 0x80, with junk in unused flag bits (R2).
    task automatic put_desc(input int i);
        int base = (32'h80 + 16 * i) / 4;
        mem[base]     = d_addr[i];
        mem[base + 1] = 32'd0;
        mem[base + 2] = d_len[i];
        mem[base + 3] = ($urandom & 32'hFFFF_FFFE) | 32'(d_flag[i]);
    endtask

    task automatic stream_reset();
        wr(4'd0, 32'h1);
        poll(4'd0, 32'h1, 32'h1, "R9 reset ack set");
        wr(4'd0, 32'h0);
        poll(4'd0, 32'h1, 32'h0, "R9 reset ack clear");
    endtask

    task automatic cfg(input int cyc, input int last, input bit le, input int lim);
        wr(4'd2, 32'h80);
        wr(4'd3, 32'h0);
        wr(4'd4, cyc);
        wr(4'd5, last);
        wr(4'd6, lim);
        wr(4'd7, 32'(le));
    endtask

    // Walk the programmed ring from entry 0 and compare received words (R2, R4, R7).
    task automatic compare_rx(input int base, input int cnt, output int bytes, output bit saw_done);
        int di, ofs, rem, n;
        logic [3:0] ek;
        logic [31:0] ew;
        bit el;
        di = 0; ofs = 0; bytes = 0; saw_done = 0;
        for (int k = 0; k < cnt; k++) begin
            rem = d_len[di] - ofs;
            n = (rem > 4) ? 4 : rem;
            ek = keepf(n);
            ew = maskw(mem[(d_addr[di] + ofs) / 4], ek);
            el = (rem <= 4);
            check(rx_data[base + k] == ew, "R7 R4 data", rx_data[base + k], ew);
            check(rx_keep[base + k] == ek && rx_last[base + k] == el, "R7 keep/last",
                  {rx_keep[base + k], 3'b0, rx_last[base + k]}, {ek, 3'b0, el});
            bytes += n;
            if (el && d_flag[di]) saw_done = 1;
            if (el) begin
                ofs = 0;
                di = (di == nd - 1) ? 0 : di + 1;
            end else ofs += 4;
        end
    endtask

    bit finished = 0;
    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int base, bytes, cyc;
        bit sd;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd0, v); check(v == 0, "R1 ctrl", v, 0);
        rd(4'd1, v); check(v == 0, "R1 status", v, 0);
        rd(4'd8, v); check(v == 0, "R1 position", v, 0);
        check(!irq && !out_valid && !mem_req_valid, "R1 outputs",
              {irq, out_valid, mem_req_valid}, 0);

        // R3: ring base low bits ignored
        wr(4'd2, 32'h1234_5FFF);
        rd(4'd2, v); check(v == 32'h1234_5F80, "R3 ring base", v, 32'h1234_5F80);

        // Directed ring: lengths 8, 6, 13; only entry 1 requests completion.
        nd = 3;
        d_addr[0] = 32'h400; d_len[0] = 8;  d_flag[0] = 0;
        d_addr[1] = 32'h500; d_len[1] = 6;  d_flag[1] = 1;
        d_addr[2] = 32'h600; d_len[2] = 13; d_flag[2] = 0;
        for (int i = 0; i < 3; i++) put_desc(i);
        cfg(27, 2, 1'b1, 10);
        rdy_pct = 100;
        cur_tag = 4'd5;
        base = rx_cnt;
        wr(4'd0, 32'h0050_0006);
        poll(4'd0, 32'h2, 32'h2, "R10 run readback");

        // R6: stall before a word crossing the limit at 10.
        repeat (80) @(negedge clk);
        check(rx_cnt - base == 2, "R6 words before limit", rx_cnt - base, 2);
        rd(4'd8, v); check(v == 8, "R6 stall position", v, 8);
        rd(4'd1, v); check(v[0] == 0, "R11 unflagged entry leaves done clear", v, 0);
        wr(4'd6, 32'd14);
        repeat (80) @(negedge clk);
        check(rx_cnt - base == 4, "R6 words after limit 14", rx_cnt - base, 4);
        rd(4'd8, v); check(v == 14, "R6 position 14", v, 14);
        rd(4'd1, v); check(v[0] == 1, "R11 flagged entry sets done", v, 1);
        check(!irq, "R11 irq gated by global enable", irq, 0);
        wr(4'd6, 32'd3);
        repeat (100) @(negedge clk);
        check(rx_cnt - base == 8, "R6 words after wrapped limit", rx_cnt - base, 8);
        rd(4'd8, v); check(v == 0, "R5 position wraps at cyclic length", v, 0);
        compare_rx(base, 8, bytes, sd);

        glob_irq_en = 1'b1;
        #1 check(irq, "R11 irq with both enables", irq, 1);
        wr(4'd1, 32'h1);
        #1 check(!irq, "R11 w1c clears done and irq", irq, 0);

        wr(4'd0, 32'h0050_0004);
        poll(4'd0, 32'h2, 32'h0, "R10 stop readback");
        check(tag_bad == 0, "R7 tag on stream", tag_bad, 0);

        // R9: reset handshake clears position.
        wr(4'd0, 32'h1);
        poll(4'd0, 32'h1, 32'h1, "R9 reset ack set");
        rd(4'd8, v); check(v == 0, "R9 position zero in reset", v, 0);
        wr(4'd0, 32'h0);
        poll(4'd0, 32'h1, 32'h0, "R9 reset ack clear");

        // Random rings with backpressure (R4, R5, R7, R8, R11).
        for (int it = 0; it < 4; it++) begin
            nd = 1 + ($urandom % 4);
            cyc = 0;
            for (int i = 0; i < nd; i++) begin
                d_addr[i] = 32'h400 + i * 32'h100 + 4 * ($urandom % 8);
                d_len[i]  = 1 + ($urandom % 12);
                d_flag[i] = $urandom % 2;
                cyc += d_len[i];
                put_desc(i);
            end
            stream_reset();
            wr(4'd1, 32'h3);
            cfg(cyc, nd - 1, 1'b0, 0);
            cur_tag = 4'(it + 9);
            rdy_pct = 40;
            base = rx_cnt;
            wr(4'd0, {8'd0, cur_tag, 20'h2});
            repeat (250) @(negedge clk);
            wr(4'd0, {8'd0, cur_tag, 20'h0});
            poll(4'd0, 32'h2, 32'h0, "R10 stop after in-flight read");
            rdy_pct = 100;
            repeat (20) @(negedge clk);
            check(rx_cnt - base > nd, "R4 ring wrapped", rx_cnt - base, nd + 1);
            compare_rx(base, rx_cnt - base, bytes, sd);
            rd(4'd8, v); check(v == bytes % cyc, "R5 R8 position matches delivered bytes", v, bytes % cyc);
            rd(4'd1, v); check(v[0] == sd, "R11 done matches flagged completions", v[0], sd);
        end
        check(tag_bad == 0, "R7 tag on stream", tag_bad, 0);

        // R12: zero-length descriptor faults.
        nd = 2;
        d_addr[0] = 32'h400; d_len[0] = 8; d_flag[0] = 0;
        d_addr[1] = 32'h500; d_len[1] = 0; d_flag[1] = 0;
        put_desc(0); put_desc(1);
        stream_reset();
        wr(4'd1, 32'h3);
        cfg(8, 1, 1'b0, 0);
        cur_tag = 4'd0;
        base = rx_cnt;
        wr(4'd0, 32'h6);
        repeat (60) @(negedge clk);
        rd(4'd1, v); check(v[1] == 1, "R12 zero length sets error", v, 2);
        rd(4'd0, v); check(v[1] == 0, "R12 run cleared by fault", v, 0);
        check(rx_cnt - base == 2, "R12 words before fault", rx_cnt - base, 2);
        check(irq, "R11 R12 error raises irq", irq, 1);
        wr(4'd1, 32'h2);
        #1 check(!irq, "R11 w1c error clears irq", irq, 0);

        // R12: read error response on a data word.
        nd = 1;
        d_addr[0] = 32'h400; d_len[0] = 8; d_flag[0] = 0;
        put_desc(0);
        stream_reset();
        cfg(8, 0, 1'b0, 0);
        err_addr = 64'h404;
        base = rx_cnt;
        wr(4'd0, 32'h2);
        repeat (60) @(negedge clk);
        rd(4'd1, v); check(v[1] == 1, "R12 read error sets error", v, 2);
        rd(4'd0, v); check(v[1] == 0, "R12 run cleared by read error", v, 0);
        check(rx_cnt - base == 1, "R12 words before read error", rx_cnt - base, 1);
        check(!irq, "R11 irq off without stream enable", irq, 0);
        wr(4'd0, 32'h4);
        #1 check(irq, "R11 irq on with stream enable", irq, 1);
        err_addr = '1;

        finish_run();
    end
endmodule